// File: doc/BRIEF.md
# No-Turnaround Synchronous SRAM

This block is a synchronous static memory with a small on-chip array of 36-bit words, split into four 9-bit byte lanes. Address, chip selects, write enable, load control and lane enables are registered on every enabled rising clock edge. Write data is taken a fixed number of edges after its command: two edges later in pipelined timing and one edge later in flow-through timing. That delay equals the read latency, so reads and writes can follow one another on every cycle without an idle cycle to turn the bus around.

A static mode input picks the timing. In pipelined timing, read data passes through an output register and appears after the edge that follows the command edge. In flow-through timing it appears right after the command edge. Data is returned on a dedicated output bus with a valid flag. When the flag is low the bus reads as zero, which stands in for an undriven pad. A read issued while an older write to the same word is still waiting for its data returns the merged result. Burst address generation lives outside the block: on a continue cycle, the block repeats the last loaded operation using whatever address the external sequencer presents.

Top module: `nbt_sram`

## Requirements
- R1: A read is accepted on a rising edge when `clk_en_n`=0, `sel_a_n`=0, `sel_b`=1, `sel_c_n`=0, `we_n`=1 and `load_n`=0.
- R2: In pipelined timing (`flow_thru`=0), read data and `dout_valid`=1 appear after the second enabled edge counted from the command edge (the command edge is the first). They do not appear after the command edge itself.
- R3: In flow-through timing (`flow_thru`=1), read data and `dout_valid`=1 appear directly after the command edge.
- R4: In pipelined timing, the data for a write is sampled from `din` on the third enabled edge (the command edge is the first).
- R5: In flow-through timing, the data for a write is sampled from `din` on the second enabled edge (the command edge is the first).
- R6: `lane_wr_n[i]`=0 writes bits `din[9i+8:9i]`. Lanes whose enable is 1 keep their contents. A write with all four enables at 1 changes nothing.
- R7: An edge with `clk_en_n`=1 changes no state and performs no write. A read result that is already on the output stays valid through the stall.
- R8: A load cycle with any of `sel_a_n`=1, `sel_b`=0 or `sel_c_n`=1 is a deselect: it causes no access and produces no `dout_valid`.
- R9: `oe_n`=1 forces `dout_valid` to 0 at any time, without a clock. A write slot never raises `dout_valid`. `dout` is all zeros whenever `dout_valid`=0.
- R10: In pipelined timing, a read whose address matches a write still waiting for its data returns that data merged by lane with the stored word.
- R11: After reset, every pipeline stage holds a deselect: `dout_valid`=0, `dout`=0, and no write takes place.
- R12: A cycle with `load_n`=1 repeats the operation type of the last load cycle (read, write or deselect), using the current `addr` and `lane_wr_n`. The chip selects and `we_n` are ignored on such a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline stages |
| flow_thru | input | 1 | Static timing select: 1 flow-through, 0 pipelined |
| clk_en_n | input | 1 | Active-low clock enable; high stalls the block |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| load_n | input | 1 | Low: load a new command; high: continue the previous one |
| addr | input | AW | Word address |
| lane_wr_n | input | LANES | Active-low write enable for each byte lane |
| oe_n | input | 1 | Output enable, active low |
| din | input | LANES*LW | Late write data |
| dout | output | LANES*LW | Read data, zero when not valid |
| dout_valid | output | 1 | Read data is present on dout |

## Verification
The bench goes after read-write-read streams with no gap between commands. A design that samples write data on the wrong edge stores the data meant for the neighbouring write, or stores bus garbage. It reads a word while a partial write to it is still waiting for its data; a design without forwarding returns the old word. It stalls with a read result already on the output and while a write command is presented, expecting the result to stay valid and the write to be dropped, where a wrong design would lose the output or commit the write. It also checks continue cycles after loads of each kind and the two timing modes separately, because an off-by-one in either latency shows up as valid data one cycle early or one cycle late.

// File: rtl/nbt_sram_pkg.sv
package nbt_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Operation selected on a load cycle from the three selects and write enable.
  function automatic op_e load_op(input logic sa_n, input logic sb,
                                  input logic sc_n, input logic w_n);
    if (sa_n || !sb || sc_n) return OP_IDLE;
    return w_n ? OP_READ : OP_WRITE;
  endfunction

endpackage

// File: rtl/nbt_cmd_pipe.sv
module nbt_cmd_pipe
  import nbt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             we_n,
  input  logic             load_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_wr_n,
  output op_e              s1_op,
  output logic [AW-1:0]    s1_addr,
  output logic [LANES-1:0] s1_be,
  output op_e              s2_op,
  output logic [AW-1:0]    s2_addr,
  output logic [LANES-1:0] s2_be
);

  op_e burst_op;
  op_e cur_op;
  logic step;

  assign step   = !clk_en_n;
  assign cur_op = load_n ? burst_op : load_op(sel_a_n, sel_b, sel_c_n, we_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_op    <= OP_IDLE;
      s2_op    <= OP_IDLE;
      s1_addr  <= '0;
      s2_addr  <= '0;
      s1_be    <= '0;
      s2_be    <= '0;
      burst_op <= OP_IDLE;
    end else if (step) begin
      s1_op   <= cur_op;
      s1_addr <= addr;
      s1_be   <= ~lane_wr_n;
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_be   <= s1_be;
      if (!load_n) burst_op <= cur_op;
    end
  end

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s2_op) && $stable(s2_be))) // R7
    else $error("stall changed pipeline state");

  AST_DESELECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !load_n && (sel_a_n || !sel_b || sel_c_n)) |=> (s1_op == OP_IDLE)) // R8
    else $error("deselect entered pipeline as access");

  AST_STAGE_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_n |=> (s2_op == $past(s1_op))) // R2
    else $error("stage two did not follow stage one");

endmodule

// File: rtl/nbt_array.sv
module nbt_array #(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DEPTH = 1 << AW,
  localparam int DW    = LANES * LW
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [LANES-1:0] wr_be,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [DW-1:0]    rd_data
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && wr_be[g]) mem[wr_addr] <= wr_data[g*LW +: LW];
    end
    assign rd_data[g*LW +: LW] = mem[rd_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      AST_WR_HAS_LANE: assert (wr_be != '0) else $error("write with no lane"); // R6
    end
  end

endmodule

// File: rtl/nbt_read_path.sv
module nbt_read_path
  import nbt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en_n,
  input  logic             flow_thru,
  input  logic             oe_n,
  input  op_e              s1_op,
  input  logic [AW-1:0]    s1_addr,
  input  op_e              s2_op,
  input  logic [AW-1:0]    s2_addr,
  input  logic [LANES-1:0] s2_be,
  input  logic [DW-1:0]    din,
  input  logic [DW-1:0]    arr_data,
  output logic [DW-1:0]    dout,
  output logic             dout_valid
);

  function automatic logic [DW-1:0] merge_lanes(input logic [DW-1:0] base,
                                                input logic [DW-1:0] upd,
                                                input logic [LANES-1:0] be);
    logic [DW-1:0] r;
    r = base;
    for (int i = 0; i < LANES; i++)
      if (be[i]) r[i*LW +: LW] = upd[i*LW +: LW];
    return r;
  endfunction

  logic          fwd_hit;
  logic [DW-1:0] fwd_data;
  logic [DW-1:0] out_q;
  logic          out_vq;
  logic          slot_read;
  logic [DW-1:0] slot_data;

  // A write in stage two commits on the same edge that loads the output register.
  assign fwd_hit  = !flow_thru && (s2_op == OP_WRITE) && (s2_addr == s1_addr);
  assign fwd_data = fwd_hit ? merge_lanes(arr_data, din, s2_be) : arr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      out_vq <= 1'b0;
    end else if (!clk_en_n) begin
      out_q  <= fwd_data;
      out_vq <= (s1_op == OP_READ);
    end
  end

  assign slot_read  = flow_thru ? (s1_op == OP_READ) : out_vq;
  assign slot_data  = flow_thru ? arr_data : out_q;
  assign dout_valid = slot_read && !oe_n;
  assign dout       = dout_valid ? slot_data : '0;

  AST_PIPE_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en_n && !flow_thru && s1_op == OP_READ) |=> (dout_valid || oe_n)) // R2
    else $error("pipelined read data missing");

  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((!flow_thru && s2_op == OP_WRITE) || (flow_thru && s1_op == OP_WRITE)) |-> !dout_valid) // R9
    else $error("output valid during write slot");

endmodule

// File: rtl/nbt_sram.sv
module nbt_sram
  import nbt_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4,
  parameter int LW    = 9,
  localparam int DW   = LANES * LW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flow_thru,
  input  logic             clk_en_n,
  input  logic             sel_a_n,
  input  logic             sel_b,
  input  logic             sel_c_n,
  input  logic             we_n,
  input  logic             load_n,
  input  logic [AW-1:0]    addr,
  input  logic [LANES-1:0] lane_wr_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_valid
);

  op_e              s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_be, s2_be;
  logic             commit_wr;
  logic [AW-1:0]    commit_addr;
  logic [LANES-1:0] commit_be;
  logic [DW-1:0]    arr_data;

  nbt_cmd_pipe #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
    .we_n(we_n), .load_n(load_n), .addr(addr), .lane_wr_n(lane_wr_n),
    .s1_op(s1_op), .s1_addr(s1_addr), .s1_be(s1_be),
    .s2_op(s2_op), .s2_addr(s2_addr), .s2_be(s2_be)
  );

  // Single late write takes stage one, double late write takes stage two.
  assign commit_addr = flow_thru ? s1_addr : s2_addr;
  assign commit_be   = flow_thru ? s1_be : s2_be;
  assign commit_wr   = !clk_en_n && (commit_be != '0) &&
                       ((flow_thru ? s1_op : s2_op) == OP_WRITE);

  nbt_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_array (
    .clk(clk), .wr_en(commit_wr), .wr_addr(commit_addr), .wr_be(commit_be),
    .wr_data(din), .rd_addr(s1_addr), .rd_data(arr_data)
  );

  nbt_read_path #(.AW(AW), .LANES(LANES), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .clk_en_n(clk_en_n), .flow_thru(flow_thru),
    .oe_n(oe_n), .s1_op(s1_op), .s1_addr(s1_addr), .s2_op(s2_op),
    .s2_addr(s2_addr), .s2_be(s2_be), .din(din), .arr_data(arr_data),
    .dout(dout), .dout_valid(dout_valid)
  );

  AST_FLOW_READ_NOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_thru && s1_op == OP_READ && !oe_n) |-> dout_valid) // R3
    else $error("flow-through read not presented");

  AST_QUIET_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_valid |-> (dout == '0)) // R9
    else $error("output bus not quiet");

endmodule

// File: tb/nbt_sram_bench.sv
module nbt_sram_bench;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int LANES = 4;
  localparam int LW = 9;
  localparam int DW = LANES * LW;

  localparam logic [DW-1:0] D1  = 36'h123456789;
  localparam logic [DW-1:0] D10 = 36'hABCDEF012;
  localparam logic [DW-1:0] D11 = 36'h0F0F0F0F0;
  localparam logic [DW-1:0] DA  = 36'h111111111;
  localparam logic [DW-1:0] D30 = 36'h2468ACE13;
  localparam logic [DW-1:0] D40 = 36'h5A5A5A5A5;
  localparam logic [DW-1:0] D41 = 36'h3C3C3C3C3;
  localparam logic [DW-1:0] JUNK = 36'hFFFFFFFFF;

  logic clk = 1'b0;
  logic rst_n, flow_thru, clk_en_n, sel_a_n, sel_b, sel_c_n, we_n, load_n, oe_n;
  logic [AW-1:0] addr;
  logic [LANES-1:0] lane_wr_n;
  logic [DW-1:0] din, dout;
  logic dout_valid;
  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  nbt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) u_nbt_sram (
    .clk(clk), .rst_n(rst_n), .flow_thru(flow_thru), .clk_en_n(clk_en_n),
    .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n), .we_n(we_n),
    .load_n(load_n), .addr(addr), .lane_wr_n(lane_wr_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_valid(dout_valid)
  );

  task automatic chk_v(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s valid act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic chk_d(input string req, input logic [DW-1:0] exp);
    n_chk++;
    if (dout_valid !== 1'b1 || dout !== exp) begin
      n_fail++;
      $display("FAIL %s data act=%h/%b exp=%h/1", req, dout, dout_valid, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #2;
  endtask

  task automatic cmd_rd(input logic [AW-1:0] a);
    clk_en_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    we_n = 1; load_n = 0; addr = a; lane_wr_n = 4'hF;
  endtask

  task automatic cmd_wr(input logic [AW-1:0] a, input logic [LANES-1:0] bw);
    clk_en_n = 0; sel_a_n = 0; sel_b = 1; sel_c_n = 0;
    we_n = 0; load_n = 0; addr = a; lane_wr_n = bw;
  endtask

  task automatic cmd_desel;
    clk_en_n = 0; sel_a_n = 1; sel_b = 1; sel_c_n = 0;
    we_n = 1; load_n = 0; lane_wr_n = 4'hF;
  endtask

  task automatic cmd_cont(input logic [AW-1:0] a, input logic [LANES-1:0] bw);
    clk_en_n = 0; load_n = 1; addr = a; lane_wr_n = bw;
    sel_a_n = 1; we_n = 1;
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 0; flow_thru = mode; oe_n = 0; din = '0; addr = '0;
    cmd_desel();
    repeat (3) tick();
    rst_n = 1;
    tick();
    chk_v("R11 reset valid", dout_valid, 1'b0);
    n_chk++;
    if (dout !== '0) begin
      n_fail++;
      $display("FAIL R11 reset dout act=%h exp=0", dout);
    end
  endtask

  task automatic t_write_read;
    cmd_wr(5, 4'h0); tick();
    cmd_desel(); tick();
    din = D1; tick();
    cmd_rd(5); tick();
    chk_v("R2 no data after command edge", dout_valid, 1'b0);
    cmd_desel(); tick();
    chk_d("R1 R2 R4 pipelined read", D1);
  endtask

  task automatic t_back_to_back;
    cmd_wr(10, 4'h0); tick();
    cmd_rd(5); tick();
    cmd_wr(11, 4'h0); din = D10; tick();
    chk_d("R2 back-to-back read", D1);
    cmd_rd(10); din = JUNK; tick();
    chk_v("R9 write slot quiet", dout_valid, 1'b0);
    cmd_desel(); din = D11; tick();
    chk_d("R4 late write data edge", D10);
    cmd_rd(11); din = JUNK; tick();
    cmd_desel(); tick();
    chk_d("R4 second late write", D11);
  endtask

  task automatic t_forward;
    cmd_wr(20, 4'h0); tick();
    cmd_desel(); tick();
    din = DA; tick();
    cmd_wr(20, 4'b1110); din = JUNK; tick();
    cmd_rd(20); tick();
    cmd_desel(); din = 36'h0000001FF; tick();
    chk_d("R10 forwarded merge", {DA[35:9], 9'h1FF});
    din = JUNK;
    cmd_rd(20); tick();
    cmd_desel(); tick();
    chk_d("R6 lane zero only", {DA[35:9], 9'h1FF});
  endtask

  task automatic t_abort;
    cmd_wr(5, 4'hF); tick();
    cmd_desel(); tick();
    din = JUNK; tick();
    cmd_rd(5); tick();
    cmd_desel(); tick();
    chk_d("R6 abort keeps word", D1);
  endtask

  task automatic t_stall;
    cmd_rd(5); tick();
    clk_en_n = 1; tick();
    chk_v("R7 stall before output", dout_valid, 1'b0);
    tick();
    chk_v("R7 stall twice", dout_valid, 1'b0);
    cmd_desel(); tick();
    chk_d("R7 read after stall", D1);
    clk_en_n = 1; tick();
    chk_d("R7 held output", D1);
    cmd_wr(5, 4'h0); clk_en_n = 1; din = JUNK; tick(); tick();
    cmd_desel(); tick(); tick(); tick();
    cmd_rd(5); tick();
    cmd_desel(); tick();
    chk_d("R7 stalled write dropped", D1);
  endtask

  task automatic t_deselect;
    cmd_rd(5); sel_b = 0; tick();
    cmd_desel(); tick();
    chk_v("R8 deselect read", dout_valid, 1'b0);
    cmd_wr(5, 4'h0); sel_c_n = 1; tick();
    cmd_desel(); tick();
    din = JUNK; tick();
    cmd_rd(5); tick();
    cmd_desel(); tick();
    chk_d("R8 deselect write no access", D1);
  endtask

  task automatic t_oe;
    cmd_rd(5); tick();
    cmd_desel(); tick();
    oe_n = 1; #1;
    chk_v("R9 oe forces off", dout_valid, 1'b0);
    n_chk++;
    if (dout !== '0) begin
      n_fail++;
      $display("FAIL R9 dout act=%h exp=0", dout);
    end
    oe_n = 0; #1;
    chk_d("R9 oe restores", D1);
  endtask

  task automatic t_continue;
    cmd_rd(5); tick();
    cmd_cont(10, 4'hF); tick();
    chk_d("R12 loaded read", D1);
    cmd_desel(); tick();
    chk_d("R12 continued read", D10);
    cmd_desel(); tick();
    cmd_cont(5, 4'hF); sel_a_n = 0; tick();
    cmd_desel(); tick();
    chk_v("R12 continue after deselect", dout_valid, 1'b0);
    cmd_wr(40, 4'h0); tick();
    cmd_cont(41, 4'h0); tick();
    cmd_desel(); din = D40; tick();
    din = D41; tick();
    din = JUNK;
    cmd_rd(41); tick();
    cmd_rd(40); tick();
    chk_d("R12 continued write", D41);
    cmd_desel(); tick();
    chk_d("R12 loaded write", D40);
  endtask

  task automatic t_flow;
    do_reset(1'b1);
    cmd_wr(30, 4'h0); tick();
    cmd_rd(30); din = D30; tick();
    chk_d("R3 R5 flow read after write", D30);
    cmd_desel(); din = JUNK; tick();
    chk_v("R3 flow deselect", dout_valid, 1'b0);
    cmd_wr(30, 4'b0111); tick();
    cmd_desel(); din = JUNK; tick();
    cmd_rd(30); din = '0; tick();
    chk_d("R5 R6 flow lane three", {9'h1FF, D30[26:0]});
    clk_en_n = 1; tick();
    chk_d("R7 flow held", {9'h1FF, D30[26:0]});
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    t_write_read();
    t_back_to_back();
    t_forward();
    t_abort();
    t_stall();
    t_deselect();
    t_oe();
    t_continue();
    t_flow();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule